// File: doc/BRIEF.md
# Dual-Precision Shift-Add Multiply-Accumulate Lane

This block is one multiply-accumulate lane for fixed-point neural-network inference. A mode bit selects one of two precisions. In the wide mode the lane forms one signed 8-bit by 8-bit product on each valid beat. In the narrow mode it forms four independent signed 4-bit by 4-bit products on each valid beat, taking its operands from packed 16-bit activation and weight words. No multiplier cell is used. Each weight bit picks a shifted copy of its activation, and these partial-product rows are summed from the most significant weight bit down to the least significant. The row that belongs to the sign bit is subtracted.

A small truncation depth can suppress the lowest weight-bit rows, which allows a narrow accumulator. A single segmented adder chain serves both modes. In the narrow mode the carries between the four segments are blocked, so the same adders produce four sums. Mode and depth are captured when a clear beat starts a new accumulation. A clear beat also loads the new product into the accumulators instead of adding it to them. The results are registered and saturate at their signed limits.

Top module: `simd_shiftadd_mac`

## Requirements
- R1: Wide mode (mode 0) uses act_i[7:0] and wgt_i[7:0] as signed 8-bit values. The 16-bit accumulator is presented on sum_o sign-extended to 40 bits.
- R2: Narrow mode (mode 1) uses lane s operands act_i[4s+3:4s] and wgt_i[4s+3:4s] as signed 4-bit values, for s = 0..3. Lane s's 10-bit accumulator appears at sum_o[10s+9:10s].
- R3: In narrow mode no lane's value, carry or saturation changes any other lane's result.
- R4: A truncation depth t (0..3) ignores the t least significant weight bits. The product equals act times (weight with its low t bits forced to zero), computed per lane in narrow mode.
- R5: Mode and depth are captured only on a beat with valid_i and clear_i both high. That beat and every later beat use the captured values. mode_i and trunc_i on other beats have no effect.
- R6: A valid beat with clear_i high loads the accumulator(s) with the new product. A valid beat with clear_i low adds the product to the accumulator(s).
- R7: The wide accumulator saturates to [-32768, 32767]. Each narrow accumulator saturates to [-512, 511].
- R8: valid_o is high exactly one cycle after a valid_i beat. Without valid_i, sum_o holds and clear_i has no effect.
- R9: After a synchronous reset, sum_o is 0, valid_o is 0, the captured mode is wide and the captured depth is 0.
- R10: In wide mode act_i[15:8] and wgt_i[15:8] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands present this cycle |
| clear_i | input | 1 | Start a new accumulation; capture mode and depth |
| mode_i | input | 1 | 0: one 8x8 MAC, 1: four 4x4 MACs |
| trunc_i | input | 2 | Number of low weight bits ignored |
| act_i | input | 16 | Packed activations |
| wgt_i | input | 16 | Packed weights |
| valid_o | output | 1 | Accumulator updated last cycle |
| sum_o | output | 40 | Accumulator(s), packed by mode |

## Verification
The bench drives the 8-bit and 4-bit sign-bit extremes, including -128 times -128 and -8 times -8. A design that added the sign row instead of subtracting it would give the wrong sign or magnitude on these cases. Mixed-lane runs push lane 0 past its positive limit and lane 1 past its negative limit while lane 2 accumulates small values. A leaking carry or a shared saturation flag would then corrupt lane 2. Beats with clear_i low carry a different mode and depth, and beats without valid_i carry clear_i. A design that sampled these fields at the wrong time would change the results. The wide mode is also fed nonzero upper bytes, which an unmasked row generator would mix into the product.

// File: rtl/ss_mac_pkg.sv
package ss_mac_pkg;
  typedef enum logic {
    PREC_W8 = 1'b0,
    PREC_N4 = 1'b1
  } prec_e;
endpackage

// File: rtl/ss_row_gen.sv
// Partial-product rows, row 0 belongs to the most significant weight bit.
module ss_row_gen
  import ss_mac_pkg::*;
#(
  parameter int AW    = 8,
  parameter int NW    = 4,
  parameter int NSUB  = 4,
  parameter int SEG_W = 11,
  parameter int TW    = 2,
  localparam int IN_W  = NSUB * NW,
  localparam int TOT_W = NSUB * SEG_W
) (
  input  prec_e                      prec,
  input  logic [TW-1:0]              depth,
  input  logic [IN_W-1:0]            act,
  input  logic [IN_W-1:0]            wgt,
  output logic [AW-1:0][TOT_W-1:0]   rows
);
  logic signed [TOT_W-1:0] wide_v;
  logic signed [SEG_W-1:0] seg_v;

  always_comb begin
    rows   = '0;
    wide_v = '0;
    seg_v  = '0;
    if (prec == PREC_W8) begin
      for (int r = 0; r < AW; r++) begin
        if (wgt[AW-1-r] && ((AW-1-r) >= int'(depth))) begin
          wide_v = TOT_W'($signed(act[AW-1:0]));
          wide_v = wide_v <<< (AW-1-r);
          rows[r] = (r == 0) ? -wide_v : wide_v;
        end
      end
    end else begin
      for (int r = 0; r < NW; r++) begin
        for (int s = 0; s < NSUB; s++) begin
          if (wgt[s*NW + NW-1-r] && ((NW-1-r) >= int'(depth))) begin
            seg_v = SEG_W'($signed(act[s*NW +: NW]));
            seg_v = seg_v <<< (NW-1-r);
            rows[r][s*SEG_W +: SEG_W] = (r == 0) ? -seg_v : seg_v;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ss_seg_adder.sv
// Adder split into segments; carries cross segment borders only when wide.
module ss_seg_adder #(
  parameter int NSEG  = 4,
  parameter int SEG_W = 11,
  localparam int TOT_W = NSEG * SEG_W
) (
  input  logic             wide,
  input  logic [TOT_W-1:0] a,
  input  logic [TOT_W-1:0] b,
  output logic [TOT_W-1:0] sum
);
  logic [NSEG:0] chain;
  assign chain[0] = 1'b0;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic cin_l;
    if (s == 0) begin : g_first
      assign cin_l = 1'b0;
    end else begin : g_next
      assign cin_l = wide & chain[s];
    end
    assign {chain[s+1], sum[s*SEG_W +: SEG_W]} =
      {1'b0, a[s*SEG_W +: SEG_W]} + {1'b0, b[s*SEG_W +: SEG_W]} +
      {{SEG_W{1'b0}}, cin_l};
  end
endmodule

// File: rtl/ss_acc_sat.sv
// Saturation per mode and output accumulator register.
module ss_acc_sat
  import ss_mac_pkg::*;
#(
  parameter int NSUB    = 4,
  parameter int SEG_W   = 11,
  parameter int NACC_W  = 10,
  parameter int WACC_W  = 16,
  localparam int TOT_W = NSUB * SEG_W,
  localparam int OUT_W = NSUB * NACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  prec_e            prec,
  input  logic [TOT_W-1:0] total,
  output logic [OUT_W-1:0] sum_q
);
  localparam logic signed [TOT_W-1:0] WMAX =
    {{(TOT_W-WACC_W+1){1'b0}}, {(WACC_W-1){1'b1}}};
  localparam logic signed [TOT_W-1:0] WMIN =
    {{(TOT_W-WACC_W+1){1'b1}}, {(WACC_W-1){1'b0}}};
  localparam logic signed [SEG_W-1:0] SMAX =
    {{(SEG_W-NACC_W+1){1'b0}}, {(NACC_W-1){1'b1}}};
  localparam logic signed [SEG_W-1:0] SMIN =
    {{(SEG_W-NACC_W+1){1'b1}}, {(NACC_W-1){1'b0}}};

  logic [OUT_W-1:0]  sat_n;
  logic [TOT_W-1:0]  wclip;
  logic [SEG_W-1:0]  seg;

  always_comb begin
    sat_n = '0;
    wclip = total;
    seg   = '0;
    if (prec == PREC_W8) begin
      if ($signed(total) > WMAX)      wclip = WMAX;
      else if ($signed(total) < WMIN) wclip = WMIN;
      sat_n = OUT_W'($signed(wclip[WACC_W-1:0]));
    end else begin
      for (int s = 0; s < NSUB; s++) begin
        seg = total[s*SEG_W +: SEG_W];
        if ($signed(seg) > SMAX)      seg = SMAX;
        else if ($signed(seg) < SMIN) seg = SMIN;
        sat_n[s*NACC_W +: NACC_W] = seg[NACC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     sum_q <= '0;
    else if (en) sum_q <= sat_n;
  end
endmodule

// File: rtl/simd_shiftadd_mac.sv
module simd_shiftadd_mac
  import ss_mac_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NW     = 4,
  parameter int NSUB   = 4,
  parameter int NACC_W = 10,
  parameter int WACC_W = 16,
  localparam int TW    = $clog2(NW),
  localparam int IN_W  = NSUB * NW,
  localparam int SEG_W = NACC_W + 1,
  localparam int TOT_W = NSUB * SEG_W,
  localparam int OUT_W = NSUB * NACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             clear_i,
  input  logic             mode_i,
  input  logic [TW-1:0]    trunc_i,
  input  logic [IN_W-1:0]  act_i,
  input  logic [IN_W-1:0]  wgt_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] sum_o
);
  prec_e            prec_q, prec_eff;
  logic [TW-1:0]    depth_q, depth_eff;
  logic             start;
  logic [TOT_W-1:0] acc_unpk, addend, total;
  logic [AW-1:0][TOT_W-1:0] rows;
  logic [TOT_W-1:0] part [AW];

  assign start     = valid_i & clear_i;
  assign prec_eff  = start ? prec_e'(mode_i) : prec_q;
  assign depth_eff = start ? trunc_i : depth_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prec_q  <= PREC_W8;
      depth_q <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (start) begin
        prec_q  <= prec_e'(mode_i);
        depth_q <= trunc_i;
      end
    end
  end

  ss_row_gen #(.AW(AW), .NW(NW), .NSUB(NSUB), .SEG_W(SEG_W), .TW(TW)) u_rows (
    .prec(prec_eff), .depth(depth_eff), .act(act_i), .wgt(wgt_i), .rows(rows)
  );

  // Rows summed most significant first through a chain of segmented adders.
  assign part[0] = rows[0];
  for (genvar r = 1; r < AW; r++) begin : g_chain
    ss_seg_adder #(.NSEG(NSUB), .SEG_W(SEG_W)) u_add (
      .wide(prec_eff == PREC_W8), .a(part[r-1]), .b(rows[r]), .sum(part[r])
    );
  end

  // Stored accumulator widened to the segmented adder format.
  always_comb begin
    acc_unpk = '0;
    if (prec_q == PREC_W8) begin
      acc_unpk = TOT_W'($signed(sum_o[WACC_W-1:0]));
    end else begin
      for (int s = 0; s < NSUB; s++)
        acc_unpk[s*SEG_W +: SEG_W] = SEG_W'($signed(sum_o[s*NACC_W +: NACC_W]));
    end
  end

  assign addend = clear_i ? '0 : acc_unpk;

  ss_seg_adder #(.NSEG(NSUB), .SEG_W(SEG_W)) u_acc_add (
    .wide(prec_eff == PREC_W8), .a(part[AW-1]), .b(addend), .sum(total)
  );

  ss_acc_sat #(.NSUB(NSUB), .SEG_W(SEG_W), .NACC_W(NACC_W), .WACC_W(WACC_W)) u_sat (
    .clk(clk), .rst(rst), .en(valid_i), .prec(prec_eff), .total(total), .sum_q(sum_o)
  );
endmodule

// File: rtl/ss_mac_checker.sv
module ss_mac_checker #(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 40,
  parameter int WACC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_i,
  input logic             clear_i,
  input logic             mode_i,
  input logic [IN_W-1:0]  act_i,
  input logic [IN_W-1:0]  wgt_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] sum_o,
  input logic             mode_q
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);  // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o);  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(sum_o));  // R8
  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !clear_i) |=> $stable(mode_q));  // R5
  AST_W8_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !mode_q) |-> (sum_o[OUT_W-1:WACC_W] == {(OUT_W-WACC_W){sum_o[WACC_W-1]}}));  // R1
  AST_CLEAR_ZERO_WGT: assert property (@(posedge clk) disable iff (rst)
    (valid_i && clear_i && wgt_i == '0) |=> (sum_o == '0));  // R6
  AST_N4_ZERO_ACT: assert property (@(posedge clk) disable iff (rst)
    (valid_i && clear_i && mode_i && act_i == '0) |=> (sum_o == '0));  // R2
endmodule

bind simd_shiftadd_mac ss_mac_checker #(.IN_W(IN_W), .OUT_W(OUT_W), .WACC_W(WACC_W)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .clear_i(clear_i), .mode_i(mode_i),
  .act_i(act_i), .wgt_i(wgt_i), .valid_o(valid_o), .sum_o(sum_o), .mode_q(prec_q)
);

// File: tb/tb_simd_shiftadd_mac.sv
module tb_simd_shiftadd_mac;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i, clear_i, mode_i;
  logic [1:0]  trunc_i;
  logic [15:0] act_i, wgt_i;
  logic        valid_o;
  logic [39:0] sum_o;

  int nvec = 0;
  int nbad = 0;

  // reference state
  logic    m_mode;
  int      m_depth;
  int      m_accw;
  int      m_accn [4];

  typedef struct packed {
    logic        mode;
    logic [1:0]  trunc;
    logic        clr;
    logic [15:0] act;
    logic [15:0] wgt;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b1, 16'hAB05, 16'hCD07},  // R1 R10 upper bytes junk
    '{1'b0, 2'd0, 1'b0, 16'h00FD, 16'h0009},  // R6 add
    '{1'b0, 2'd0, 1'b0, 16'h0080, 16'h0080},  // R1 -128*-128
    '{1'b0, 2'd2, 1'b1, 16'hFF64, 16'h1217},  // R4 depth 2
    '{1'b1, 2'd3, 1'b0, 16'h0011, 16'h00FF},  // R5 mode/depth ignored
    '{1'b0, 2'd3, 1'b1, 16'h007F, 16'h0081},  // R4 depth 3
    '{1'b1, 2'd0, 1'b1, 16'h7F18, 16'h8F27},  // R2 narrow clear
    '{1'b1, 2'd0, 1'b0, 16'h1234, 16'h4321},  // R2 accumulate
    '{1'b1, 2'd0, 1'b0, 16'h8888, 16'h8888},  // R2 -8*-8 each lane
    '{1'b1, 2'd1, 1'b1, 16'h9A5C, 16'hB6E3},  // R4 narrow depth 1
    '{1'b0, 2'd0, 1'b0, 16'hC3D1, 16'h7777},  // R5 wide mode ignored
    '{1'b1, 2'd3, 1'b1, 16'h7E21, 16'h9F8C},  // R4 sign-bit row only
    '{1'b0, 2'd1, 1'b1, 16'h55C7, 16'hAA3B},  // R1 back to wide
    '{1'b0, 2'd2, 1'b0, 16'h0081, 16'h00F6}   // R5 depth kept at 1
  };

  simd_shiftadd_mac dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .clear_i(clear_i), .mode_i(mode_i),
    .trunc_i(trunc_i), .act_i(act_i), .wgt_i(wgt_i), .valid_o(valid_o), .sum_o(sum_o)
  );

  always #5 clk = ~clk;

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic logic [39:0] model_out();
    logic [39:0] o;
    if (!m_mode) o = 40'($signed(m_accw[15:0]));
    else for (int s = 0; s < 4; s++) o[s*10 +: 10] = m_accn[s][9:0];
    return o;
  endfunction

  task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic beat(input logic m, input logic [1:0] t, input logic c,
                      input logic [15:0] a, input logic [15:0] w, input string req);
    int mask, p;
    valid_i = 1'b1; clear_i = c; mode_i = m; trunc_i = t; act_i = a; wgt_i = w;
    if (c) begin m_mode = m; m_depth = int'(t); end
    mask = ~((1 << m_depth) - 1);
    if (!m_mode) begin
      p = int'($signed(a[7:0])) * (int'($signed(w[7:0])) & mask);
      m_accw = clampi(c ? p : m_accw + p, -32768, 32767);
    end else begin
      for (int s = 0; s < 4; s++) begin
        p = int'($signed(a[s*4 +: 4])) * (int'($signed(w[s*4 +: 4])) & mask);
        m_accn[s] = clampi(c ? p : m_accn[s] + p, -512, 511);
      end
    end
    @(negedge clk);
    valid_i = 1'b0; clear_i = 1'b0;
    check(req, sum_o, model_out());
    check({req, " valid_o R8"}, {39'd0, valid_o}, 40'd1);
  endtask

  initial begin
    for (int i = 0; i < 50000; i++) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; clear_i = 1'b0; mode_i = 1'b0; trunc_i = 2'd0;
    act_i = '0; wgt_i = '0;
    m_mode = 1'b0; m_depth = 0; m_accw = 0;
    for (int s = 0; s < 4; s++) m_accn[s] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset sum", sum_o, 40'd0);
    check("R9 reset valid", {39'd0, valid_o}, 40'd0);
    // R9: default mode wide, depth 0, accumulator zero
    beat(1'b1, 2'd3, 1'b0, 16'h00F3, 16'h0045, "R9 default mode");

    for (int i = 0; i < NV; i++)
      beat(VECS[i].mode, VECS[i].trunc, VECS[i].clr, VECS[i].act, VECS[i].wgt, "R1/R2 table");

    // R8: idle cycle with clear and a new mode does nothing
    begin
      logic [39:0] keep;
      keep = sum_o;
      clear_i = 1'b1; mode_i = ~m_mode; act_i = 16'h1111; wgt_i = 16'h2222;
      @(negedge clk);
      clear_i = 1'b0;
      check("R8 idle hold", sum_o, keep);
      check("R8 idle valid", {39'd0, valid_o}, 40'd0);
      beat(mode_i, 2'd0, 1'b0, 16'h0003, 16'h0002, "R8 no capture while idle");
    end

    // R7: wide positive and negative saturation
    beat(1'b0, 2'd0, 1'b1, 16'h007F, 16'h007F, "R7 wide pos");
    for (int i = 0; i < 2; i++) beat(1'b0, 2'd0, 1'b0, 16'h007F, 16'h007F, "R7 wide pos sat");
    check("R7 wide max", sum_o, 40'($signed(16'h7FFF)));
    beat(1'b0, 2'd0, 1'b1, 16'h0080, 16'h007F, "R7 wide neg");
    for (int i = 0; i < 2; i++) beat(1'b0, 2'd0, 1'b0, 16'h0080, 16'h007F, "R7 wide neg sat");
    check("R7 wide min", sum_o, 40'($signed(16'h8000)));

    // R3 R7: lanes 0/1 saturate opposite ways, lane 2 keeps counting
    beat(1'b1, 2'd0, 1'b1, 16'h0378, 16'h5288, "R3 narrow start");
    for (int i = 0; i < 9; i++) beat(1'b1, 2'd0, 1'b0, 16'h0378, 16'h5288, "R3 narrow run");
    check("R7 lane0 max", 40'(sum_o[9:0]), 40'(10'h1FF));
    check("R7 lane1 min", 40'(sum_o[19:10]), 40'(10'h200));
    check("R3 lane2 isolated", 40'(sum_o[29:20]), 40'(10'd60));

    // R9: reset mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_mode = 1'b0; m_depth = 0; m_accw = 0;
    check("R9 reset again", sum_o, 40'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule